// File: doc/BRIEF.md
# Palette DAC Hidden Control Unlock

This block sits beside a VGA palette DAC and watches the processor's I/O accesses to the four DAC ports. A run of back-to-back reads of the pixel-mask port unlocks a concealed control byte. While the run has reached its full length, the mask port reads and writes that byte instead of the ordinary pixel mask. An access to any other DAC port breaks the run. So does a write to the mask port.

The captured control byte is combined with the extended-mode byte of the sequencer to produce a pixel-depth code for the rest of the display path. When extended mode is on, the depth field picks the colour depth. For the two 16-bit settings, bit 0 of the concealed byte picks between 5-5-5 and 5-6-5 pixels.

Top module: `dac_unlock_top`

## Requirements
- R1: After reset the run counter is 0, the concealed control byte is 0x00, the pixel mask is 0xFF and the depth code is 0 (standard VGA).
- R2: The mask port is at I/O offset 6. Each read strobe on it, with no write strobe, adds one to the run counter. The counter stops at 4 and holds there on further reads.
- R3: A read of the mask port returns the concealed control byte while the counter is 4, and the pixel mask otherwise. Reads of any other offset return 0x00.
- R4: A write to the mask port while the counter is 4 loads the concealed control byte, leaves the pixel mask unchanged and returns the counter to 0.
- R5: A write to the mask port while the counter is below 4 loads the pixel mask, leaves the concealed byte unchanged and returns the counter to 0.
- R6: A read or a write at offset 7 (read index), offset 8 (write index) or offset 9 (palette data) returns the counter to 0.
- R7: When sequencer mode bit 0 (extended enable) is 0, the depth code is 0, whatever the depth field holds.
- R8: When bit 0 is 1, sequencer bits [3:1] select the depth code: field 0 gives code 1 (8 bpp), field 2 gives code 4 (24 bpp), field 4 gives code 5 (32 bpp), and fields 5 to 7 give code 0.
- R9: Field 1 (16 bpp with doubled clock) and field 3 (16 bpp) give code 3 (16 bpp) when concealed byte bit 0 is 1, and code 2 (15 bpp) when it is 0.
- R10: When the read and write strobes are both asserted on the mask port in the same cycle, only the write takes effect.
- R11: Accesses at offsets outside 6 to 9 leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | I/O port offset within the display register window |
| io_rd | input | 1 | Read strobe, one access per cycle |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_wdata | input | 8 | Write data |
| seq_mode | input | 8 | Sequencer extended-mode byte: bit 0 enables, bits [3:1] give the depth field |
| io_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| hid_ctrl | output | 8 | Concealed control byte |
| pix_mask | output | 8 | Pixel mask byte |
| depth | output | 3 | Depth code: 0 VGA, 1 8bpp, 2 15bpp, 3 16bpp, 4 24bpp, 5 32bpp |

## Verification
Two functions can meet in one cycle at the mask port. The read that would advance the run can coincide with the write that either consumes the unlock or clears it. The bench provokes this by asserting both strobes at the saturated count. It then judges the outcome at the ports: the concealed byte must take the data, the pixel mask must stay as it was, and a following read must return the mask, which shows the counter went to 0 rather than staying at 4. The same clash is also driven below the unlock point, where the pixel mask must take the data.

// File: rtl/dac_unlock_pkg.sv
package dac_unlock_pkg;

    typedef enum logic [2:0] {
        DEPTH_VGA = 3'd0,
        DEPTH_8   = 3'd1,
        DEPTH_15  = 3'd2,
        DEPTH_16  = 3'd3,
        DEPTH_24  = 3'd4,
        DEPTH_32  = 3'd5
    } depth_e;

    // decoded view of one bus cycle
    typedef struct packed {
        logic mask_rd;
        logic mask_wr;
        logic other_dac;
    } dac_access_t;

endpackage

// File: rtl/dac_port_decode.sv
module dac_port_decode #(
    parameter int ADDR_W   = 4,
    parameter int MASK_OFS = 6,
    parameter int RIDX_OFS = 7,
    parameter int WIDX_OFS = 8,
    parameter int DATA_OFS = 9
) (
    input  logic [ADDR_W-1:0]           io_addr,
    input  logic                        io_rd,
    input  logic                        io_wr,
    output dac_unlock_pkg::dac_access_t acc
);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] RIDX_A = ADDR_W'(RIDX_OFS);
    localparam logic [ADDR_W-1:0] WIDX_A = ADDR_W'(WIDX_OFS);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

    logic is_mask;
    logic is_other;

    always_comb begin
        is_mask  = (io_addr == MASK_A);
        is_other = (io_addr == RIDX_A) || (io_addr == WIDX_A) || (io_addr == DATA_A);
        // a write on the mask port wins over a read in the same cycle
        acc.mask_wr   = io_wr && is_mask;
        acc.mask_rd   = io_rd && !io_wr && is_mask;
        acc.other_dac = (io_rd || io_wr) && is_other;
    end
endmodule

// File: rtl/dac_unlock_ctr.sv
module dac_unlock_ctr #(
    parameter int UNLOCK_RUNS = 4,
    parameter int CNT_W       = $clog2(UNLOCK_RUNS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  dac_unlock_pkg::dac_access_t acc,
    output logic [CNT_W-1:0]            cnt,
    output logic                        unlocked
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(UNLOCK_RUNS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc.mask_wr || acc.other_dac) begin
            st_d.cnt = '0;
        end else if (acc.mask_rd && (st_q.cnt != LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt      = st_q.cnt;
    assign unlocked = (st_q.cnt == LIMIT);
endmodule

// File: rtl/dac_ext_regs.sv
module dac_ext_regs #(
    parameter int          DATA_W   = 8,
    parameter logic [DATA_W-1:0] MASK_RST = '1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  dac_unlock_pkg::dac_access_t acc,
    input  logic                        unlocked,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rd_mask_port,
    output logic [DATA_W-1:0]           hid_ctrl,
    output logic [DATA_W-1:0]           pix_mask
);
    typedef struct packed {
        logic [DATA_W-1:0] hid;
        logic [DATA_W-1:0] mask;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc.mask_wr) begin
            if (unlocked) begin
                st_d.hid = wdata;
            end else begin
                st_d.mask = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hid  <= '0;
            st_q.mask <= MASK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_mask_port = unlocked ? st_q.hid : st_q.mask;
    assign hid_ctrl     = st_q.hid;
    assign pix_mask     = st_q.mask;
endmodule

// File: rtl/dac_depth_dec.sv
module dac_depth_dec #(
    parameter int MODE_W = 8
) (
    input  logic [MODE_W-1:0]      seq_mode,
    input  logic                   wide_sel,
    output dac_unlock_pkg::depth_e depth
);
    import dac_unlock_pkg::*;

    logic [2:0] field;
    depth_e     sixteen;

    always_comb begin
        field   = seq_mode[3:1];
        sixteen = wide_sel ? DEPTH_16 : DEPTH_15;
        depth   = DEPTH_VGA;
        if (seq_mode[0]) begin
            unique case (field)
                3'd0:       depth = DEPTH_8;
                3'd1, 3'd3: depth = sixteen;
                3'd2:       depth = DEPTH_24;
                3'd4:       depth = DEPTH_32;
                default:    depth = DEPTH_VGA;
            endcase
        end
    end
endmodule

// File: rtl/dac_unlock_top.sv
module dac_unlock_top #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int UNLOCK_RUNS = 4,
    parameter int MASK_OFS    = 6,
    parameter int RIDX_OFS    = 7,
    parameter int WIDX_OFS    = 8,
    parameter int DATA_OFS    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic [7:0]        seq_mode,
    output logic [DATA_W-1:0] io_rdata,
    output logic [DATA_W-1:0] hid_ctrl,
    output logic [DATA_W-1:0] pix_mask,
    output logic [2:0]        depth
);
    import dac_unlock_pkg::*;

    localparam int CNT_W = $clog2(UNLOCK_RUNS + 1);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

    dac_access_t       acc;
    logic [CNT_W-1:0]  cnt_q;
    logic              unlocked;
    logic [DATA_W-1:0] mask_port_val;
    depth_e            depth_code;

    dac_port_decode #(
        .ADDR_W  (ADDR_W),
        .MASK_OFS(MASK_OFS),
        .RIDX_OFS(RIDX_OFS),
        .WIDX_OFS(WIDX_OFS),
        .DATA_OFS(DATA_OFS)
    ) u_dec (
        .io_addr(io_addr),
        .io_rd  (io_rd),
        .io_wr  (io_wr),
        .acc    (acc)
    );

    dac_unlock_ctr #(
        .UNLOCK_RUNS(UNLOCK_RUNS),
        .CNT_W      (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .cnt     (cnt_q),
        .unlocked(unlocked)
    );

    dac_ext_regs #(
        .DATA_W(DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc         (acc),
        .unlocked    (unlocked),
        .wdata       (io_wdata),
        .rd_mask_port(mask_port_val),
        .hid_ctrl    (hid_ctrl),
        .pix_mask    (pix_mask)
    );

    dac_depth_dec #(
        .MODE_W(8)
    ) u_depth (
        .seq_mode(seq_mode),
        .wide_sel(hid_ctrl[0]),
        .depth   (depth_code)
    );

    always_comb begin
        io_rdata = '0;
        if (io_rd && (io_addr == MASK_A)) begin
            io_rdata = mask_port_val;
        end
    end

    assign depth = depth_code;
endmodule

// File: rtl/dac_unlock_checker.sv
module dac_unlock_checker #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int UNLOCK_RUNS = 4,
    parameter int CNT_W       = 3,
    parameter int MASK_OFS    = 6,
    parameter int RIDX_OFS    = 7,
    parameter int WIDX_OFS    = 8,
    parameter int DATA_OFS    = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_wdata,
    input logic [7:0]        seq_mode,
    input logic [CNT_W-1:0]  cnt,
    input logic [DATA_W-1:0] hid_ctrl,
    input logic [DATA_W-1:0] pix_mask,
    input logic [2:0]        depth
);
    localparam logic [CNT_W-1:0]  LIMIT  = CNT_W'(UNLOCK_RUNS);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

    logic on_mask, on_other;
    assign on_mask  = (io_addr == MASK_A);
    assign on_other = (io_addr == ADDR_W'(RIDX_OFS)) || (io_addr == ADDR_W'(WIDX_OFS))
                   || (io_addr == ADDR_W'(DATA_OFS));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && on_mask && cnt != LIMIT) |=> (cnt == $past(cnt) + 1'b1));

    // R2
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

    // R4
    hid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && on_mask && cnt == LIMIT)
        |=> (hid_ctrl == $past(io_wdata)) && $stable(pix_mask) && (cnt == '0));

    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && on_mask && cnt != LIMIT)
        |=> (pix_mask == $past(io_wdata)) && $stable(hid_ctrl) && (cnt == '0));

    // R6
    idx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && on_other) |=> (cnt == '0));

    // R7
    vga_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_mode[0] |-> (depth == 3'd0));
endmodule

bind dac_unlock_top dac_unlock_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .UNLOCK_RUNS(UNLOCK_RUNS),
    .CNT_W      (CNT_W),
    .MASK_OFS   (MASK_OFS),
    .RIDX_OFS   (RIDX_OFS),
    .WIDX_OFS   (WIDX_OFS),
    .DATA_OFS   (DATA_OFS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_addr (io_addr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .io_wdata(io_wdata),
    .seq_mode(seq_mode),
    .cnt     (cnt_q),
    .hid_ctrl(hid_ctrl),
    .pix_mask(pix_mask),
    .depth   (depth)
);

// File: tb/dac_unlock_top_bench.sv
module dac_unlock_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] io_addr = 4'h0;
    logic       io_rd = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] seq_mode = 8'h00;
    logic [7:0] io_rdata;
    logic [7:0] hid_ctrl;
    logic [7:0] pix_mask;
    logic [2:0] depth;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [3:0] A_MASK = 4'h6, A_RIDX = 4'h7, A_WIDX = 4'h8, A_DATA = 4'h9, A_OFF = 4'h2;

    always #10 clk = ~clk;

    dac_unlock_top u_dac_unlock_top (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .seq_mode(seq_mode), .io_rdata(io_rdata),
        .hid_ctrl(hid_ctrl), .pix_mask(pix_mask), .depth(depth)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        #2 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic mask_reads(input int n);
        logic [7:0] d;
        for (int i = 0; i < n; i++) bus_rd(A_MASK, d);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        do_reset();
        check("R1 hid", hid_ctrl, 8'h00);
        check("R1 mask", pix_mask, 8'hFF);
        check("R1 depth", {5'd0, depth}, 8'h00);
        mask_reads(4);
        bus_rd(A_MASK, d);
        check("R1 counter starts at zero", d, 8'h00);
    endtask

    task automatic t_unlock_write;
        logic [7:0] d;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            bus_rd(A_MASK, d);
            check("R3 locked read gives mask", d, 8'hFF);
        end
        bus_rd(A_MASK, d);
        check("R3 unlocked read gives hidden", d, 8'h00);
        mask_reads(3);
        bus_rd(A_MASK, d);
        check("R2 saturated at unlock", d, 8'h00);
        bus_wr(A_MASK, 8'hA5);
        check("R4 hidden loaded", hid_ctrl, 8'hA5);
        check("R4 mask kept", pix_mask, 8'hFF);
        bus_rd(A_MASK, d);
        check("R4 counter back to zero", d, 8'hFF);
        bus_rd(A_OFF, d);
        check("R3 other offset reads zero", d, 8'h00);
    endtask

    task automatic t_locked_write;
        logic [7:0] d;
        do_reset();
        mask_reads(2);
        bus_wr(A_MASK, 8'h3C);
        check("R5 mask loaded", pix_mask, 8'h3C);
        check("R5 hidden kept", hid_ctrl, 8'h00);
        mask_reads(3);
        bus_rd(A_MASK, d);
        check("R5 counter cleared by write", d, 8'h3C);
        bus_rd(A_MASK, d);
        check("R5 unlock after full run", d, 8'h00);
    endtask

    task automatic t_cancel(input logic [3:0] a, input bit use_wr, input string tag);
        logic [7:0] d;
        do_reset();
        mask_reads(3);
        if (use_wr) bus_wr(a, 8'h11); else bus_rd(a, d);
        mask_reads(3);
        bus_rd(A_MASK, d);
        check({"R6 cancel ", tag}, d, 8'hFF);
        bus_rd(A_MASK, d);
        check({"R6 reunlock ", tag}, d, 8'h00);
    endtask

    task automatic t_foreign;
        logic [7:0] d;
        do_reset();
        mask_reads(3);
        bus_rd(A_OFF, d);
        bus_wr(A_OFF, 8'h77);
        mask_reads(1);
        bus_rd(A_MASK, d);
        check("R11 foreign offset keeps run", d, 8'h00);
        check("R11 mask untouched", pix_mask, 8'hFF);
    endtask

    task automatic t_clash;
        logic [7:0] d;
        do_reset();
        mask_reads(4);
        io_addr = A_MASK; io_wdata = 8'h5A; io_rd = 1'b1; io_wr = 1'b1;
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0;
        check("R10 clash write hits hidden", hid_ctrl, 8'h5A);
        check("R10 clash mask kept", pix_mask, 8'hFF);
        bus_rd(A_MASK, d);
        check("R10 clash counter zero", d, 8'hFF);
        io_addr = A_MASK; io_wdata = 8'hC3; io_rd = 1'b1; io_wr = 1'b1;
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0;
        check("R10 low clash write hits mask", pix_mask, 8'hC3);
        check("R10 low clash hidden kept", hid_ctrl, 8'h5A);
    endtask

    task automatic set_mode(input logic [7:0] m, input logic [2:0] exp, input string req);
        seq_mode = m;
        #1 check(req, {5'd0, depth}, {5'd0, exp});
    endtask

    task automatic t_depth;
        do_reset();
        set_mode(8'h00, 3'd0, "R7 vga field0");
        set_mode(8'h08, 3'd0, "R7 vga field4");
        set_mode(8'h06, 3'd0, "R7 vga field3");
        set_mode(8'h01, 3'd1, "R8 8bpp");
        set_mode(8'h05, 3'd4, "R8 24bpp");
        set_mode(8'h09, 3'd5, "R8 32bpp");
        set_mode(8'h0B, 3'd0, "R8 reserved5");
        set_mode(8'h0F, 3'd0, "R8 reserved7");
        set_mode(8'h03, 3'd2, "R9 dbl 15bpp");
        set_mode(8'h07, 3'd2, "R9 15bpp");
        mask_reads(4);
        bus_wr(A_MASK, 8'h01);
        set_mode(8'h03, 3'd3, "R9 dbl 16bpp");
        set_mode(8'h07, 3'd3, "R9 16bpp");
        set_mode(8'h05, 3'd4, "R9 24 ignores bit0");
        seq_mode = 8'h00;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_unlock_write();
        t_locked_write();
        t_cancel(A_RIDX, 1'b0, "ridx rd");
        t_cancel(A_WIDX, 1'b1, "widx wr");
        t_cancel(A_DATA, 1'b0, "data rd");
        t_cancel(A_DATA, 1'b1, "data wr");
        t_foreign();
        t_clash();
        t_depth();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule